// File: doc/BRIEF.md
# Base Address Window Decoder

This block compares an incoming bus address against six address windows and reports which window claims it. Each window is described by a decode base and a size. The configuration logic supplies both. The base already includes the offset of the I/O or memory space that the window type selects. A window takes part in matching only when its base is non-zero. A size of zero also keeps the window out of matching.

The comparison is done by combinational logic across all six windows. A fixed-priority pick then chooses one window, and a single register stage holds the outputs. Each address with its valid strobe produces a hit flag, the index of the chosen window and the offset of the address inside that window, one clock later. When the configuration logic signals that the window set has changed, the result of that cycle is dropped. The downstream logic then never acts on a decode made against a half-updated set.

Top module: `bar_window_decoder`

## Requirements
- R1: Six windows are evaluated. An address presented with `addr_vld_i` high in one cycle produces its result on `hit_o`, `idx_o` and `off_o` after the next rising clock edge.
- R2: A window whose base is zero never matches.
- R3: A window whose size is zero never matches.
- R4: A window with a power-of-two size S and an S-aligned base B matches exactly the addresses from B to B+S-1. B-1 and B+S do not match it.
- R5: When several windows match, the window with the lowest index (0 to 5) is reported.
- R6: On a hit, `off_o` equals the address minus the matched base. This is the address bits below log2(S).
- R7: When `addr_vld_i` is low, `hit_o` is low in the following cycle.
- R8: When `range_chg_i` is high, `hit_o` is low in the following cycle, whatever the address.
- R9: After a synchronous reset, `hit_o`, `idx_o` and `off_o` are all zero.
- R10: Whenever `hit_o` is low, `idx_o` and `off_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| range_chg_i | input | 1 | Window set changed; drop this cycle's decode |
| win_base_i | input | 6*ADDR_W | Decode bases, window k in bits [k*ADDR_W +: ADDR_W] |
| win_size_i | input | 6*ADDR_W | Window sizes (power of two or zero), same packing |
| addr_vld_i | input | 1 | Address strobe |
| addr_i | input | ADDR_W | Bus address to decode |
| hit_o | output | 1 | Registered: address fell inside an enabled window |
| idx_o | output | 3 | Registered index of the chosen window |
| off_o | output | ADDR_W | Registered offset inside the chosen window |

## Verification
An error in a window comparator appears at the ports one cycle after an address lands on the boundary of that window. It shows as a wrong hit flag at B-1, B+S-1 or B+S, or as a disabled window that claims an address. A priority error appears only where windows overlap, so overlapping windows are set up on purpose and shown as a wrong `idx_o`. Invalidation and strobe errors show as a stray `hit_o` in the cycle right after `range_chg_i` or an idle strobe.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
  localparam int NUM_WIN    = 6;
  localparam int DEF_ADDR_W = 32;
endpackage

// File: rtl/bar_win_match.sv
module bar_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] off_o
);
  logic [ADDR_W-1:0] low_mask;
  logic              enabled;

  always_comb begin
    low_mask = size_i - ADDR_W'(1);
    enabled  = (base_i != '0) && (size_i != '0);
    match_o  = enabled && ((addr_i & ~low_mask) == (base_i & ~low_mask));
    off_o    = addr_i & low_mask;
  end
endmodule

// File: rtl/bar_prio_pick.sv
module bar_prio_pick #(
  parameter int N      = 6,
  parameter int ADDR_W = 32,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*ADDR_W-1:0] off_i,
  output logic                any_o,
  output logic [IW-1:0]       idx_o,
  output logic [ADDR_W-1:0]   off_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    off_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IW'(k);
        off_o = off_i[k*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
  parameter int ADDR_W = bar_dec_pkg::DEF_ADDR_W,
  localparam int NWIN  = bar_dec_pkg::NUM_WIN,
  localparam int IW    = $clog2(NWIN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   range_chg_i,
  input  logic [NWIN*ADDR_W-1:0] win_base_i,
  input  logic [NWIN*ADDR_W-1:0] win_size_i,
  input  logic                   addr_vld_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic                   hit_o,
  output logic [IW-1:0]          idx_o,
  output logic [ADDR_W-1:0]      off_o
);
  logic [NWIN-1:0]        match_vec;
  logic [NWIN*ADDR_W-1:0] off_vec;
  logic                   pick_any;
  logic [IW-1:0]          pick_idx;
  logic [ADDR_W-1:0]      pick_off;
  logic                   take;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    bar_win_match #(.ADDR_W(ADDR_W)) u_match (
      .base_i (win_base_i[g*ADDR_W +: ADDR_W]),
      .size_i (win_size_i[g*ADDR_W +: ADDR_W]),
      .addr_i (addr_i),
      .match_o(match_vec[g]),
      .off_o  (off_vec[g*ADDR_W +: ADDR_W])
    );
  end

  bar_prio_pick #(.N(NWIN), .ADDR_W(ADDR_W)) u_pick (
    .req_i(match_vec),
    .off_i(off_vec),
    .any_o(pick_any),
    .idx_o(pick_idx),
    .off_o(pick_off)
  );

  assign take = addr_vld_i && !range_chg_i && pick_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o <= 1'b0;
      idx_o <= '0;
      off_o <= '0;
    end else begin
      hit_o <= take;
      idx_o <= take ? pick_idx : '0;
      off_o <= take ? pick_off : '0;
    end
  end

  // Lower-index mask for the priority check
  logic [NWIN-1:0] below_pick;
  always_comb begin
    for (int k = 0; k < NWIN; k++) below_pick[k] = (IW'(k) < pick_idx);
  end

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> (match_vec[pick_idx] && ((match_vec & below_pick) == '0)));
  assert_index_range_R1: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (int'(idx_o) < NWIN));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !addr_vld_i |=> !hit_o);
  assert_invalidate_R8: assert property (@(posedge clk) disable iff (rst)
    range_chg_i |=> !hit_o);
  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (idx_o == '0 && off_o == '0));
endmodule

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
  localparam int AW = 32;
  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg = 1'b0;
  logic vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] bb [NW];
  logic [AW-1:0] sz [NW];
  logic [NW*AW-1:0] base_flat, size_flat;
  logic hit;
  logic [2:0] idx;
  logic [AW-1:0] off;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      base_flat[i*AW +: AW] = bb[i];
      size_flat[i*AW +: AW] = sz[i];
    end
  end

  bar_window_decoder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .range_chg_i(chg),
    .win_base_i(base_flat), .win_size_i(size_flat),
    .addr_vld_i(vld), .addr_i(addr),
    .hit_o(hit), .idx_o(idx), .off_o(off)
  );

  function automatic void ref_decode(input logic [AW-1:0] a, input bit v, input bit c,
                                     output bit eh, output int ei, output logic [AW-1:0] eo);
    eh = 0; ei = 0; eo = '0;
    if (!v || c) return;
    for (int i = 0; i < NW; i++) begin
      if (!eh && bb[i] != 0 && sz[i] != 0 && (a - bb[i]) < sz[i] && a >= bb[i]) begin
        eh = 1; ei = i; eo = a - bb[i];
      end
    end
  endfunction

  task automatic check(input string req, input logic [AW-1:0] a, input bit v, input bit c);
    bit eh; int ei; logic [AW-1:0] eo;
    ref_decode(a, v, c, eh, ei, eo);
    addr = a; vld = v; chg = c;
    @(posedge clk); #1;
    checks++;
    if (hit !== eh || int'(idx) != ei || off !== eo) begin
      errors++;
      $display("FAIL %s addr=%h: got hit=%0d idx=%0d off=%h, expected hit=%0d idx=%0d off=%h",
               req, a, hit, idx, off, eh, ei, eo);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NW; i++) begin bb[i] = '0; sz[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (hit !== 1'b0 || idx !== 3'd0 || off !== '0) begin
      errors++;
      $display("FAIL R9 reset: got hit=%0d idx=%0d off=%h, expected 0 0 0", hit, idx, off);
    end
    rst = 1'b0;

    // Directed layout: 0 and 1 overlap, 2 base zero, 3 size zero
    bb[0] = 32'h1000;  sz[0] = 32'h100;
    bb[1] = 32'h1000;  sz[1] = 32'h1000;
    bb[2] = 32'h0;     sz[2] = 32'h100;
    bb[3] = 32'h8000;  sz[3] = 32'h0;
    bb[4] = 32'h20000; sz[4] = 32'h10000;
    bb[5] = 32'h40000; sz[5] = 32'h4;
    check("R5 overlap low index", 32'h1000, 1, 0);
    check("R4 R6 top of window0", 32'h10FF, 1, 0);
    check("R5 past window0 falls to 1", 32'h1100, 1, 0);
    check("R4 last of window1", 32'h1FFF, 1, 0);
    check("R4 one past window1", 32'h2000, 1, 0);
    check("R4 one below base", 32'h0FFF, 1, 0);
    check("R2 zero base disabled", 32'h50, 1, 0);
    check("R3 zero size disabled", 32'h8000, 1, 0);
    check("R6 small window offset", 32'h40003, 1, 0);
    check("R4 end of small window", 32'h40004, 1, 0);
    check("R6 large window offset", 32'h2FFFF, 1, 0);
    check("R7 strobe low", 32'h1010, 0, 0);
    check("R8 range change", 32'h1010, 1, 1);
    check("R1 recovers after change", 32'h1010, 1, 0);
    check("R10 miss clears", 32'h9_0000, 1, 0);

    // Random layouts with overlap-prone bases
    for (int round = 0; round < 40; round++) begin
      for (int i = 0; i < NW; i++) begin
        int lg;
        lg = 2 + int'($urandom_range(0, 14));
        sz[i] = ($urandom_range(0, 9) == 0) ? '0 : (32'd1 << lg);
        bb[i] = (32'h0010_0000 | ($urandom & 32'h0003_FFFF)) & ~((32'd1 << lg) - 1);
        if ($urandom_range(0, 7) == 0) bb[i] = '0;
      end
      check("R8 config update", bb[0], 1, 1);
      for (int t = 0; t < 40; t++) begin
        int w;
        logic [AW-1:0] a;
        w = int'($urandom_range(0, NW - 1));
        case ($urandom_range(0, 3))
          0: a = bb[w] + sz[w] - 1;
          1: a = bb[w] + sz[w];
          2: a = bb[w] - 1;
          default: a = bb[w] + ($urandom % (sz[w] + 1));
        endcase
        check("R1 R4 R5 R6 random", a, $urandom_range(0, 9) != 0, $urandom_range(0, 19) == 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule